// File: doc/BRIEF.md
# Data-Strobe Serial Receiver with Word Resynchronizer

The block takes the two line signals of a data-strobe serial link, data and strobe, sampled in a fast receive clock domain. It finds a bit event each time the exclusive-OR of data and strobe changes value, and takes the data line at that event as the received bit. A speed code sets the word width to 2, 4 or 8 bits. Bits are packed into words with the first bit received in the most significant position of the word.

Finished words, each tagged with the speed code it was built under, cross into the local system clock domain. An asynchronous FIFO with Gray-coded pointers carries them across. On the local side each word appears for one cycle with a valid strobe. A word that arrives while the FIFO is full is dropped and raises a sticky overflow flag in the receive domain.

A change of the speed code throws away any partly built word, so the next word starts cleanly at the new width.

Top module: `ds_deser_resync`

## Requirements
- R1: A bit event occurs only when the exclusive-OR of the sampled data and strobe lines changes value, and the received bit is the data line at that event. Toggling both lines together, or holding both steady, produces no bit.
- R2: Speed code 0 builds 2-bit words, code 1 builds 4-bit words, and codes 2 and 3 build 8-bit words.
- R3: The first bit of each word lands in the most significant used bit. The word is right-aligned in `out_word`, and the unused upper bits are zero.
- R4: When the speed code changes, the partial word is discarded and the bit count restarts at the new width.
- R5: Words reach the system domain in arrival order. Each word is shown for one `sys_clk` cycle with `out_valid` high, and `out_speed` carries the speed code the word was built under.
- R6: The FIFO holds 4 words. A word completed while the FIFO is full is dropped and sets `rx_overflow`, which stays high until receive-domain reset.
- R7: While reset is held (active low, synchronous), `out_valid`, `out_word`, `out_speed` and `rx_overflow` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive sampling clock |
| rx_rst_n | input | 1 | Receive-domain synchronous reset, active low |
| rx_data | input | 1 | Received data line |
| rx_strobe | input | 1 | Received strobe line |
| rx_speed | input | 2 | Speed code selecting the word width |
| sys_clk | input | 1 | Local system clock |
| sys_rst_n | input | 1 | System-domain synchronous reset, active low |
| out_valid | output | 1 | One-cycle strobe for each delivered word |
| out_word | output | 8 | Delivered word, right-aligned |
| out_speed | output | 2 | Speed code of the delivered word |
| rx_overflow | output | 1 | Sticky flag for a word dropped on a full FIFO |

## Verification
The bench fills the FIFO while the system side is held in reset and checks that exactly four words come out and the fifth is lost. A design with an off-by-one in the full test would either deliver five words or lose the fourth. It changes speed in the middle of a word and expects only the bits sent after the change; a design that kept stale bits would emit a wrong or extra word. It toggles data and strobe together, and it repeats equal bits so that only the strobe moves. A recovery that looked at either line alone would then invent or miss bits, and byte patterns such as A5 and 3C would expose a reversed bit order.

// File: rtl/ds_pkg.sv
// Shared types for the data-strobe receiver.
// Assumes words are at most 8 bits wide.
package ds_pkg;
    typedef enum logic [1:0] {
        SPD_W2  = 2'd0,
        SPD_W4  = 2'd1,
        SPD_W8  = 2'd2,
        SPD_W8B = 2'd3
    } spd_e;

    // Number of bits in a word for a given speed code.
    function automatic logic [3:0] width_of(spd_e s);
        case (s)
            SPD_W2:  return 4'd2;
            SPD_W4:  return 4'd4;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/ds_bit_recover.sv
// Samples the data and strobe lines in the receive domain and flags a bit
// event whenever their exclusive-OR changes. Assumes each line state is held
// for at least two rx_clk cycles. The speed code is sampled in the same
// stage, so it stays aligned with the bits.
module ds_bit_recover
    import ds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    input  logic strobe_in,
    input  spd_e speed_in,
    output logic bit_evt,
    output logic bit_val,
    output spd_e speed_q
);
    logic d_r, s_r, par_r;

    // Register the line inputs and the speed code together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_r     <= 1'b0;
            s_r     <= 1'b0;
            speed_q <= SPD_W2;
        end else begin
            d_r     <= data_in;
            s_r     <= strobe_in;
            speed_q <= speed_in;
        end
    end

    // Keep the previous data^strobe parity for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) par_r <= 1'b0;
        else        par_r <= d_r ^ s_r;
    end

    // A change of parity is one recovered bit.
    always_comb begin
        bit_evt = (d_r ^ s_r) ^ par_r;
        bit_val = d_r;
    end

    // R1
    evt_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_evt |=> (par_r != $past(par_r)));
endmodule

// File: rtl/ds_word_pack.sv
// Packs recovered bits MSB-first into words whose width follows the speed
// code. Assumes bit_evt, bit_val and speed are aligned in one cycle. A change
// of speed drops the partial word.
module ds_word_pack
    import ds_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_evt,
    input  logic              bit_val,
    input  spd_e              speed,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output spd_e              push_spd
);
    logic [WORD_W-1:0] sh, cur_sh, nxt_sh;
    logic [CNT_W-1:0]  cnt, cur_cnt;
    spd_e              last_spd;
    logic              chg, done;

    // Decide whether this cycle flushes, extends or finishes the word.
    always_comb begin
        chg     = (speed != last_spd);
        cur_sh  = chg ? '0 : sh;
        cur_cnt = chg ? '0 : cnt;
        nxt_sh  = {cur_sh[WORD_W-2:0], bit_val};
        done    = bit_evt && (cur_cnt == CNT_W'(width_of(speed) - 4'd1));
    end

    // Shift register, bit counter and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            cnt       <= '0;
            last_spd  <= SPD_W2;
            push      <= 1'b0;
            push_word <= '0;
            push_spd  <= SPD_W2;
        end else begin
            last_spd <= speed;
            push     <= done;
            if (done) begin
                push_word <= nxt_sh;
                push_spd  <= speed;
                sh        <= '0;
                cnt       <= '0;
            end else if (bit_evt) begin
                sh  <= nxt_sh;
                cnt <= cur_cnt + 1'b1;
            end else begin
                sh  <= cur_sh;
                cnt <= cur_cnt;
            end
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(width_of(last_spd)));
    // R4
    spd_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed != last_spd) |=> (cnt <= CNT_W'(1)));
    // R1
    push_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(bit_evt));
endmodule

// File: rtl/ds_async_fifo.sv
// Two-clock FIFO with Gray-coded pointers and two-flop synchronizers.
// Assumes AW >= 2. A write request on a full FIFO is dropped and sets a
// sticky overflow flag. The read side emits one word per cycle while
// not empty.
module ds_async_fifo #(
    parameter int DW = 10,
    parameter int AW = 2,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wdata,
    output logic          overflow,
    input  logic          rclk,
    input  logic          rrst_n,
    output logic          rd_valid,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rq1, rq2;
    logic [AW:0] rbin, rgray, wq1, wq2;
    logic full, empty;

    function automatic logic [AW:0] g2b(logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        full  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
        empty = (rgray == wq2);
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge wclk) begin
        if (wr_req && !full) mem[wbin[AW-1:0]] <= wdata;
    end

    // Write pointer advance and overflow capture.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else if (wr_req) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                wbin  <= wbin + 1'b1;
                wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
            end
        end
    end

    // Bring the read pointer into the write domain.
    always_ff @(posedge wclk) begin
        if (!wrst_n) {rq2, rq1} <= '0;
        else         {rq2, rq1} <= {rq1, rgray};
    end

    // Bring the write pointer into the read domain.
    always_ff @(posedge rclk) begin
        if (!rrst_n) {wq2, wq1} <= '0;
        else         {wq2, wq1} <= {wq1, wgray};
    end

    // Pop one word per cycle whenever data is present.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else if (!empty) begin
            rdata    <= mem[rbin[AW-1:0]];
            rd_valid <= 1'b1;
            rbin     <= rbin + 1'b1;
            rgray    <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R6
    ovf_sticky_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        overflow |=> overflow);
    // R6
    wr_occupancy_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wbin - g2b(rq2)) <= (AW+1)'(DEPTH));
    // R5
    rd_occupancy_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (g2b(wq2) - rbin) <= (AW+1)'(DEPTH));
endmodule

// File: rtl/ds_deser_resync.sv
// Top level: bit recovery and word packing in the rx_clk domain, then a
// Gray-pointer FIFO into the sys_clk domain. Assumes rx_clk samples each
// line state at least twice. Each word carries its speed code as a tag.
module ds_deser_resync
    import ds_pkg::*;
#(
    parameter int WORD_W  = 8,
    parameter int FIFO_AW = 2,
    localparam int FDW = WORD_W + 2
) (
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              rx_data,
    input  logic              rx_strobe,
    input  logic [1:0]        rx_speed,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [1:0]        out_speed,
    output logic              rx_overflow
);
    logic              bit_evt, bit_val, push;
    spd_e              spd_q, push_spd;
    logic [WORD_W-1:0] push_word;
    logic [FDW-1:0]    rd_data;

    ds_bit_recover u_rec (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .data_in  (rx_data),
        .strobe_in(rx_strobe),
        .speed_in (spd_e'(rx_speed)),
        .bit_evt  (bit_evt),
        .bit_val  (bit_val),
        .speed_q  (spd_q)
    );

    ds_word_pack #(.WORD_W(WORD_W)) u_pack (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .bit_evt  (bit_evt),
        .bit_val  (bit_val),
        .speed    (spd_q),
        .push     (push),
        .push_word(push_word),
        .push_spd (push_spd)
    );

    ds_async_fifo #(.DW(FDW), .AW(FIFO_AW)) u_fifo (
        .wclk    (rx_clk),
        .wrst_n  (rx_rst_n),
        .wr_req  (push),
        .wdata   ({push_spd, push_word}),
        .overflow(rx_overflow),
        .rclk    (sys_clk),
        .rrst_n  (sys_rst_n),
        .rd_valid(out_valid),
        .rdata   (rd_data)
    );

    // Split the FIFO entry into word and speed tag.
    always_comb begin
        out_word  = rd_data[WORD_W-1:0];
        out_speed = rd_data[FDW-1:WORD_W];
    end

    // R3
    upper_zero_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (out_valid && out_speed == 2'd0) |-> (out_word[WORD_W-1:2] == '0));
endmodule

// File: tb/tb_ds_deser_resync.sv
module tb_ds_deser_resync;
    logic rx_clk = 0, sys_clk = 0;
    logic rx_rst_n = 0, sys_rst_n = 0;
    logic rx_data = 0, rx_strobe = 0;
    logic [1:0] rx_speed = 0;
    logic out_valid, rx_overflow;
    logic [7:0] out_word;
    logic [1:0] out_speed;

    int checks = 0, failures = 0;
    int got_cnt = 0;
    logic [7:0] got_w [64];
    logic [1:0] got_s [64];
    bit done = 0;

    always #2.5 sys_clk = ~sys_clk;
    always #3.5 rx_clk = ~rx_clk;

    ds_deser_resync dut (
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_data(rx_data),
        .rx_strobe(rx_strobe), .rx_speed(rx_speed), .sys_clk(sys_clk),
        .sys_rst_n(sys_rst_n), .out_valid(out_valid), .out_word(out_word),
        .out_speed(out_speed), .rx_overflow(rx_overflow)
    );

    // {speed code, word}; width follows R2
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'h02}, {2'd0, 8'h01}, {2'd1, 8'h06}, {2'd1, 8'h0F},
        {2'd2, 8'hA5}, {2'd2, 8'hFF}, {2'd2, 8'h00}, {2'd3, 8'h3C}
    };

    // Collect delivered words away from the active edge.
    always @(negedge sys_clk) begin
        if (sys_rst_n && out_valid && got_cnt < 64) begin
            got_w[got_cnt] = out_word;
            got_s[got_cnt] = out_speed;
            got_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Encode one bit on the data-strobe lines.
    task automatic send_bit(input bit b);
        @(negedge rx_clk);
        if (b != rx_data) rx_data = b;
        else              rx_strobe = ~rx_strobe;
        repeat (2) @(negedge rx_clk);
    endtask

    task automatic send_word(input logic [7:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic wait_count(input int n);
        for (int t = 0; t < 3000 && got_cnt < n; t++) @(negedge sys_clk);
    endtask

    function automatic int width(input logic [1:0] s);
        return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (6) @(negedge sys_clk);
        // R7 reset state
        chk(out_valid == 0, "R7 out_valid", out_valid, 0);
        chk(out_word == 0, "R7 out_word", out_word, 0);
        chk(rx_overflow == 0, "R7 rx_overflow", rx_overflow, 0);

        // R6 fill FIFO while sys side is held in reset
        @(negedge rx_clk); rx_rst_n = 1;
        repeat (3) @(negedge rx_clk);
        send_word(8'h3, 2); send_word(8'h2, 2); send_word(8'h1, 2);
        send_word(8'h0, 2); send_word(8'h3, 2);
        repeat (10) @(negedge rx_clk);
        chk(rx_overflow == 1, "R6 overflow set", rx_overflow, 1);
        chk(got_cnt == 0, "R5 nothing while sys reset", got_cnt, 0);
        @(negedge sys_clk); sys_rst_n = 1;
        wait_count(4);
        repeat (60) @(negedge sys_clk);
        chk(got_cnt == 4, "R6 fifth word dropped", got_cnt, 4);
        for (int i = 0; i < 4; i++)
            chk(got_w[i] == 8'(3 - i), "R5 order after fill", got_w[i], 3 - i);

        // R1 R2 R3 R5 table walk
        base = got_cnt;
        for (int k = 0; k < 8; k++) begin
            @(negedge rx_clk); rx_speed = VEC[k][9:8];
            repeat (3) @(negedge rx_clk);
            send_word(VEC[k][7:0], width(VEC[k][9:8]));
            wait_count(base + k + 1);
            chk(got_w[base+k] == VEC[k][7:0], "R2 R3 word", got_w[base+k], VEC[k][7:0]);
            chk(got_s[base+k] == VEC[k][9:8], "R5 speed tag", got_s[base+k], VEC[k][9:8]);
        end
        repeat (40) @(negedge sys_clk);
        chk(got_cnt == base + 8, "R1 one word per vector", got_cnt, base + 8);

        // R4 speed change mid-word discards partial bits
        base = got_cnt;
        @(negedge rx_clk); rx_speed = 2'd2;
        repeat (3) @(negedge rx_clk);
        send_bit(1); send_bit(0); send_bit(1);
        @(negedge rx_clk); rx_speed = 2'd0;
        repeat (3) @(negedge rx_clk);
        send_bit(1); send_bit(1);
        wait_count(base + 1);
        repeat (40) @(negedge sys_clk);
        chk(got_cnt == base + 1, "R4 single word after change", got_cnt, base + 1);
        chk(got_w[base] == 8'h03, "R4 fresh word", got_w[base], 3);
        chk(got_s[base] == 2'd0, "R4 new speed tag", got_s[base], 0);

        // R1 toggling both lines together gives no bit
        base = got_cnt;
        for (int i = 0; i < 4; i++) begin
            @(negedge rx_clk);
            rx_data = ~rx_data; rx_strobe = ~rx_strobe;
            repeat (2) @(negedge rx_clk);
        end
        repeat (60) @(negedge sys_clk);
        chk(got_cnt == base, "R1 no bit on joint toggle", got_cnt, base);
        // next two real bits must form exactly one word 2'b10
        send_bit(1); send_bit(0);
        wait_count(base + 1);
        chk(got_w[base] == 8'h02, "R1 word after joint toggles", got_w[base], 2);

        chk(rx_overflow == 1, "R6 overflow sticky", rx_overflow, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule